// File: doc/BRIEF.md
# Transmit Packet Framer

This block turns a packet description and a stream of payload bytes into a serial bit stream for a radio modulator. The host pushes payload bytes into a transmit FIFO through a simple write port. Preamble length, sync word, field layout and per-field checksum choice are held on configuration inputs. A start pulse then launches one packet.

The framer sends a run of alternating-pattern preamble bytes and a sync word of one to four bytes. It follows them with up to five data fields taken from the FIFO, each of which may be followed by its own 16-bit or 32-bit CRC. Field and CRC bits can be scrambled by a pseudo-noise sequence, and the whole packet can be Manchester coded. Each pulse of a symbol-rate strobe moves the output on by one symbol. A single-cycle completion pulse marks the end of the packet. If the FIFO runs dry in the middle of a field, the packet is abandoned and an error flag is set.

The FIFO depth can be selected as the small or the large size. A level flag tells the host when the fill level has dropped to a programmable threshold, so it can top the FIFO up while a long packet is still being sent.

Top module: `pkt_framer`

## Requirements
- R1: The FIFO holds 64 bytes when `fifo_big` is 0 and 129 bytes when it is 1. A write offered while the FIFO is full is dropped, and the bytes already stored are not disturbed. `fifo_big` may only change while the FIFO is empty.
- R2: `ae_flag` is 1 exactly when the number of stored bytes is less than or equal to `ae_level`. It follows the fill level one cycle after each write or read.
- R3: A one-cycle `fifo_clr` pulse empties the FIFO, and any write presented in that same cycle is dropped.
- R4: Packet order is as follows: `pre_len` bytes of 0xAA, then sync bytes `sync_word[8*sync_len+7:0]` sent from the highest of those bytes down, then field 1, then each field k in 2..5 whose enable bit `fld_en[k-1]` is 1, in ascending order. `fld_en[0]` is ignored. Field k carries `fld_len[8k-1:8k-8]` FIFO bytes (1..255). Every byte is sent MSB first.
- R5: `crc_sel[2k-1:2k-2]` selects the checksum sent after field k. Code 1 appends 2 bytes (polynomial 0x1021, start value `crc16_seed`). Code 2 appends 4 bytes (polynomial 0x04C11DB7, start value `crc32_seed`). Codes 0 and 3 append nothing. Each CRC covers only the unscrambled bytes of its own field, bit by bit MSB first, with no reflection and no final inversion, and it is sent MSB first.
- R6: With `whiten_en` = 1, every field and CRC bit (but no preamble or sync bit) is XORed with s[0] of a 9-bit register s. The register is set to all ones at each start and steps after every such bit as s <= {s[0]^s[5], s[8:1]}.
- R7: With `manch_en` = 1, each coded bit takes two strobes: a 1 is sent as 1 then 0, and a 0 as 0 then 1. This applies to all parts of the packet.
- R8: `tx_active` rises in the cycle after `start` while idle, and each `sym_stb` cycle advances one symbol. `tx_bit` is 0 whenever `tx_active` is 0. After the last symbol, `tx_active` falls and `pkt_sent` is high for exactly that one cycle.
- R9: If a field byte is due while the FIFO is empty, the packet stops at that byte boundary. `tx_active` falls without `pkt_sent`, and `underflow` goes to 1 and stays there until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push `wr_data` into the FIFO |
| wr_data | input | 8 | Payload byte |
| fifo_clr | input | 1 | Empty the FIFO |
| fifo_big | input | 1 | 0: 64-byte FIFO, 1: 129-byte FIFO |
| ae_level | input | 8 | Almost-empty threshold |
| ae_flag | output | 1 | Fill level at or below threshold |
| start | input | 1 | Begin a packet (ignored while active) |
| pre_len | input | 8 | Preamble byte count |
| sync_word | input | 32 | Sync pattern, low bytes used |
| sync_len | input | 2 | Sync byte count minus one |
| fld_en | input | 5 | Enables for fields 2..5 (bit 0 unused) |
| fld_len | input | 40 | Byte count per field, 8 bits each |
| crc_sel | input | 10 | CRC code per field, 2 bits each |
| crc16_seed | input | 16 | Start value of 16-bit CRC |
| crc32_seed | input | 32 | Start value of 32-bit CRC |
| whiten_en | input | 1 | Scramble field and CRC bits |
| manch_en | input | 1 | Manchester-code the output |
| sym_stb | input | 1 | Symbol-rate advance strobe |
| tx_bit | output | 1 | Serial output symbol |
| tx_active | output | 1 | Packet in progress |
| pkt_sent | output | 1 | One-cycle completion pulse |
| underflow | output | 1 | Packet aborted on empty FIFO |

## Verification
The bench compares whole packets against an independent bit-level model. The packets cover skipped middle fields, back-to-back CRC sizes, the unused CRC code, scrambling and Manchester coding together, and one-byte fields. A framer that took the CRC value one bit before the final data bit, or carried CRC state from one field into the next, would give a wrong checksum. A framer that stepped the scrambler during the sync bytes would corrupt every field bit. The fill-level flag is probed at the exact threshold crossing, and a FIFO that stored past its small depth would be caught because it would avoid the expected underflow. The full 129-byte packet exercises pointer wrap, and a dropped write on the full FIFO must not replace a stored byte.

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int unsigned SMALL_DEPTH = 64,
  parameter int unsigned LARGE_DEPTH = 129,
  parameter int unsigned NUM_FIELDS  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [7:0]              wr_data,
  input  logic                    fifo_clr,
  input  logic                    fifo_big,
  input  logic [$clog2(LARGE_DEPTH+1)-1:0] ae_level,
  output logic                    ae_flag,
  input  logic                    start,
  input  logic [7:0]              pre_len,
  input  logic [31:0]             sync_word,
  input  logic [1:0]              sync_len,
  input  logic [NUM_FIELDS-1:0]   fld_en,
  input  logic [8*NUM_FIELDS-1:0] fld_len,
  input  logic [2*NUM_FIELDS-1:0] crc_sel,
  input  logic [15:0]             crc16_seed,
  input  logic [31:0]             crc32_seed,
  input  logic                    whiten_en,
  input  logic                    manch_en,
  input  logic                    sym_stb,
  output logic                    tx_bit,
  output logic                    tx_active,
  output logic                    pkt_sent,
  output logic                    underflow
);
  localparam int PW = $clog2(LARGE_DEPTH);
  localparam int CW = $clog2(LARGE_DEPTH + 1);
  localparam int FW = $clog2(NUM_FIELDS);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SYNC, S_DATA, S_CRC} st_t;
  typedef enum logic [2:0] {K_PRE, K_SYNC0, K_SYNC, K_FLD, K_DATA, K_CRC0, K_CRC, K_END} kind_t;

  logic [7:0]    mem [LARGE_DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] depth;
  logic          full, empty, do_wr, pop;

  st_t           st;
  kind_t         kind;
  logic [7:0]    sh, left;
  logic [2:0]    bitn;
  logic [FW-1:0] fld, nxt_f, tgt_f;
  logic          nxt_ok;
  logic [31:0]   crc, crc_nxt, csrc, new_seed;
  logic [8:0]    lfsr;
  logic          half, uflow, sent;
  logic [1:0]    cur_sel, new_sel, sidx, cidx;
  logic          wht_on, raw, adv, byte_end, need_byte;
  logic [15:0]   c16;
  logic [31:0]   c32;

  assign depth   = fifo_big ? CW'(LARGE_DEPTH) : CW'(SMALL_DEPTH);
  assign full    = cnt_q >= depth;
  assign empty   = cnt_q == '0;
  assign do_wr   = wr_en && !full && !fifo_clr;
  assign ae_flag = cnt_q <= ae_level;

  always_ff @(posedge clk) if (do_wr) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt_q <= '0;
    end else if (fifo_clr) begin
      wp <= '0; rp <= '0; cnt_q <= '0;
    end else begin
      if (do_wr) wp <= (wp == PW'(depth - 1'b1)) ? '0 : wp + 1'b1;
      if (pop)   rp <= (rp == PW'(depth - 1'b1)) ? '0 : rp + 1'b1;
      if (do_wr && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (!do_wr && pop) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cur_sel  = crc_sel[2*fld +: 2];
  assign wht_on   = whiten_en && (st == S_DATA || st == S_CRC);
  assign raw      = sh[7] ^ (wht_on & lfsr[0]);
  assign tx_bit   = tx_active & ((manch_en & half) ? ~raw : raw);
  assign adv      = tx_active && sym_stb && !(manch_en && !half);
  assign byte_end = adv && bitn == 3'd7;

  assign c16 = {crc[14:0], 1'b0} ^ ((crc[15] ^ sh[7]) ? 16'h1021 : 16'h0);
  assign c32 = {crc[30:0], 1'b0} ^ ((crc[31] ^ sh[7]) ? 32'h04C11DB7 : 32'h0);
  assign crc_nxt = (st != S_DATA)    ? crc :
                   (cur_sel == 2'd1) ? {16'h0, c16} :
                   (cur_sel == 2'd2) ? c32 : crc;

  always_comb begin
    nxt_ok = 1'b0;
    nxt_f  = '0;
    for (int i = NUM_FIELDS - 1; i >= 1; i--)
      if (i > int'(fld) && fld_en[i]) begin
        nxt_ok = 1'b1;
        nxt_f  = FW'(i);
      end
  end

  always_comb begin
    case (st)
      S_PRE:   kind = (left != 0) ? K_PRE  : K_SYNC0;
      S_SYNC:  kind = (left != 0) ? K_SYNC : K_FLD;
      S_DATA:  kind = (left != 0) ? K_DATA :
                      (cur_sel == 2'd1 || cur_sel == 2'd2) ? K_CRC0 :
                      nxt_ok ? K_FLD : K_END;
      S_CRC:   kind = (left != 0) ? K_CRC : nxt_ok ? K_FLD : K_END;
      default: kind = K_END;
    endcase
  end

  assign tgt_f     = (st == S_SYNC) ? '0 : nxt_f;
  assign new_sel   = crc_sel[2*tgt_f +: 2];
  assign new_seed  = (new_sel == 2'd2) ? crc32_seed : {16'h0, crc16_seed};
  assign need_byte = byte_end && (kind == K_FLD || kind == K_DATA);
  assign pop       = need_byte && !empty;
  assign sidx      = (st == S_PRE) ? sync_len : left[1:0] - 2'd1;
  assign csrc      = (st == S_DATA) ? crc_nxt : crc;
  assign cidx      = (st == S_DATA) ? ((cur_sel == 2'd2) ? 2'd3 : 2'd1) : left[1:0] - 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; left <= '0; bitn <= '0; fld <= '0;
      crc <= '0; lfsr <= '1; half <= 1'b0; tx_active <= 1'b0;
      sent <= 1'b0; uflow <= 1'b0;
    end else begin
      sent <= 1'b0;
      if (!tx_active) begin
        if (start) begin
          tx_active <= 1'b1; uflow <= 1'b0; half <= 1'b0;
          bitn <= '0; lfsr <= '1; fld <= '0;
          if (pre_len != 0) begin
            st <= S_PRE; sh <= 8'hAA; left <= pre_len - 1'b1;
          end else begin
            st <= S_SYNC; sh <= sync_word[8*sync_len +: 8]; left <= {6'd0, sync_len};
          end
        end
      end else if (sym_stb) begin
        if (manch_en && !half) begin
          half <= 1'b1;
        end else begin
          half <= 1'b0;
          if (wht_on) lfsr <= {lfsr[0] ^ lfsr[5], lfsr[8:1]};
          crc <= crc_nxt;
          if (bitn != 3'd7) begin
            bitn <= bitn + 1'b1;
            sh   <= {sh[6:0], 1'b0};
          end else begin
            bitn <= '0;
            if (need_byte && empty) begin
              st <= S_IDLE; tx_active <= 1'b0; uflow <= 1'b1;
            end else begin
              case (kind)
                K_PRE:  begin sh <= 8'hAA; left <= left - 1'b1; end
                K_SYNC0: begin st <= S_SYNC; sh <= sync_word[8*sidx +: 8]; left <= {6'd0, sync_len}; end
                K_SYNC: begin sh <= sync_word[8*sidx +: 8]; left <= left - 1'b1; end
                K_DATA: begin sh <= mem[rp]; left <= left - 1'b1; end
                K_FLD: begin
                  st <= S_DATA; fld <= tgt_f; sh <= mem[rp];
                  left <= fld_len[8*tgt_f +: 8] - 1'b1; crc <= new_seed;
                end
                K_CRC0: begin st <= S_CRC; sh <= csrc[8*cidx +: 8]; left <= {6'd0, cidx}; end
                K_CRC:  begin sh <= csrc[8*cidx +: 8]; left <= left - 1'b1; end
                default: begin st <= S_IDLE; tx_active <= 1'b0; sent <= 1'b1; end
              endcase
            end
          end
        end
      end
    end
  end

  assign pkt_sent  = sent;
  assign underflow = uflow;
endmodule

module pkt_framer_chk #(
  parameter int unsigned SMALL_DEPTH = 64,
  parameter int unsigned LARGE_DEPTH = 129
) (
  input logic clk,
  input logic rst_n,
  input logic tx_active,
  input logic tx_bit,
  input logic pkt_sent,
  input logic underflow,
  input logic manch_en,
  input logic half,
  input logic fifo_big,
  input logic [$clog2(LARGE_DEPTH+1)-1:0] cnt_q
);
  AST_SENT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) pkt_sent |=> !pkt_sent); // R8
  AST_SENT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) pkt_sent |-> !tx_active); // R8
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !tx_active |-> !tx_bit); // R8
  AST_MANCH_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (manch_en && tx_active && $rose(half)) |-> (tx_bit == !$past(tx_bit))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_big |-> cnt_q <= ($clog2(LARGE_DEPTH+1))'(SMALL_DEPTH))); // R1
  AST_BIG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ($clog2(LARGE_DEPTH+1))'(LARGE_DEPTH)); // R1
  AST_UFLOW_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> (!tx_active && !pkt_sent)); // R9
endmodule

bind pkt_framer pkt_framer_chk #(.SMALL_DEPTH(SMALL_DEPTH), .LARGE_DEPTH(LARGE_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .tx_bit(tx_bit),
  .pkt_sent(pkt_sent), .underflow(underflow), .manch_en(manch_en),
  .half(half), .fifo_big(fifo_big), .cnt_q(cnt_q)
);

// File: tb/sim_pkt_framer.sv
module sim_pkt_framer;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 83;
  // pre[82:75] slen[74:73] en[72:68] lens[67:28] sels[27:18] wh[17] mc[16] bits[15:0]
  localparam logic [VW-1:0] VEC [5] = '{
    {8'd2, 2'd1, 5'b00001, 40'h00_00_00_00_03, 10'b00_00_00_00_01, 1'b0, 1'b0, 16'd72},
    {8'd1, 2'd3, 5'b00011, 40'h00_00_00_03_02, 10'b00_00_00_00_10, 1'b1, 1'b0, 16'd112},
    {8'd0, 2'd0, 5'b10101, 40'h01_00_02_00_01, 10'b10_00_01_00_00, 1'b0, 1'b1, 16'd176},
    {8'd3, 2'd2, 5'b11111, 40'h01_01_01_01_01, 10'b01_01_01_01_01, 1'b1, 1'b1, 16'd336},
    {8'd0, 2'd3, 5'b00001, 40'h00_00_00_00_04, 10'b00_00_00_00_11, 1'b0, 1'b0, 16'd64}
  };

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, fifo_clr = 0, fifo_big = 0, start = 0, sym_stb = 0;
  logic [7:0] wr_data = 0, ae_level = 0, pre_len = 0;
  logic [31:0] sync_word = 32'hC5_2D_91_D3, crc32_seed = 32'hFFFF_FFFF;
  logic [15:0] crc16_seed = 16'h1D0F;
  logic [1:0] sync_len = 0;
  logic [4:0] fld_en = 0;
  logic [39:0] fld_len = 0;
  logic [9:0] crc_sel = 0;
  logic whiten_en = 0, manch_en = 0;
  logic ae_flag, tx_bit, tx_active, pkt_sent, underflow;

  int n_chk = 0, n_bad = 0;
  logic [7:0] pay [0:511];
  bit exp_b [0:4095];
  bit cap_b [0:4095];
  int exp_n, cap_n;
  bit saw_sent;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_framer u0 (.*);

  task automatic chk(input bit ok, input string msg, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, expv);
    end
  endtask

  function automatic logic [15:0] c16b(input logic [15:0] c, input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      logic fb = c[15] ^ b[k];
      c = {c[14:0], 1'b0};
      if (fb) c ^= 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [31:0] c32b(input logic [31:0] c, input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      logic fb = c[31] ^ b[k];
      c = {c[30:0], 1'b0};
      if (fb) c ^= 32'h04C11DB7;
    end
    return c;
  endfunction

  task automatic build_exp();
    logic [7:0] by [0:1023];
    bit wh [0:1023];
    int nb = 0, pi = 0;
    logic [8:0] s = 9'h1FF;
    for (int i = 0; i < int'(pre_len); i++) begin by[nb] = 8'hAA; wh[nb] = 0; nb++; end
    for (int i = int'(sync_len); i >= 0; i--) begin by[nb] = sync_word[8*i +: 8]; wh[nb] = 0; nb++; end
    for (int f = 0; f < 5; f++) begin
      if (f == 0 || fld_en[f]) begin
        logic [15:0] a16 = crc16_seed;
        logic [31:0] a32 = crc32_seed;
        for (int j = 0; j < int'(fld_len[8*f +: 8]); j++) begin
          by[nb] = pay[pi]; wh[nb] = 1; nb++;
          a16 = c16b(a16, pay[pi]); a32 = c32b(a32, pay[pi]); pi++;
        end
        if (crc_sel[2*f +: 2] == 2'd1)
          for (int i = 1; i >= 0; i--) begin by[nb] = a16[8*i +: 8]; wh[nb] = 1; nb++; end
        if (crc_sel[2*f +: 2] == 2'd2)
          for (int i = 3; i >= 0; i--) begin by[nb] = a32[8*i +: 8]; wh[nb] = 1; nb++; end
      end
    end
    exp_n = 0;
    for (int i = 0; i < nb; i++)
      for (int k = 7; k >= 0; k--) begin
        bit r = by[i][k];
        if (whiten_en && wh[i]) begin
          r ^= s[0];
          s = {s[0] ^ s[5], s[8:1]};
        end
        if (manch_en) begin exp_b[exp_n] = r; exp_b[exp_n+1] = ~r; exp_n += 2; end
        else begin exp_b[exp_n] = r; exp_n++; end
      end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic clear();
    @(negedge clk); fifo_clr = 1;
    @(negedge clk); fifo_clr = 0;
  endtask

  task automatic capture();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; sym_stb = 1;
    cap_n = 0;
    while (tx_active && cap_n < 4096) begin
      cap_b[cap_n] = tx_bit; cap_n++;
      @(negedge clk);
    end
    saw_sent = pkt_sent;
    sym_stb = 0;
  endtask

  task automatic cmp_stream(input string msg, input int upto);
    int bad = -1;
    for (int i = 0; i < upto; i++) if (bad < 0 && cap_b[i] != exp_b[i]) bad = i;
    chk(bad < 0, msg, bad < 0 ? 0 : cap_b[bad], bad < 0 ? 0 : exp_b[bad]);
    if (bad >= 0) $display("  first differing bit index %0d", bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int np;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 R2 reset state
    chk(!tx_active, "R8 reset tx_active", tx_active, 0);
    chk(!tx_bit && !pkt_sent, "R8 reset tx_bit/pkt_sent", {tx_bit, pkt_sent}, 0);
    chk(!underflow, "R9 reset underflow", underflow, 0);
    chk(ae_flag, "R2 reset ae_flag", ae_flag, 1);

    // table walk: R4 R5 R6 R7 R8
    for (int v = 0; v < 5; v++) begin
      logic [VW-1:0] e = VEC[v];
      pre_len = e[82:75]; sync_len = e[74:73]; fld_en = e[72:68]; fld_len = e[67:28];
      crc_sel = e[27:18]; whiten_en = e[17]; manch_en = e[16];
      crc16_seed = 16'h1D0F ^ 16'(v * 16'h0123);
      clear();
      np = 0;
      for (int f = 0; f < 5; f++) if (f == 0 || fld_en[f]) np += int'(fld_len[8*f +: 8]);
      for (int k = 0; k < np; k++) begin pay[k] = 8'h5A ^ 8'(k * 29 + v * 7); push(pay[k]); end
      build_exp();
      capture();
      chk(cap_n == int'(e[15:0]), $sformatf("R4 vector %0d symbol count", v), cap_n, e[15:0]);
      chk(exp_n == int'(e[15:0]), $sformatf("R4 vector %0d model count", v), exp_n, e[15:0]);
      cmp_stream($sformatf("R4 R5 R6 R7 vector %0d stream", v), exp_n);
      chk(saw_sent, $sformatf("R8 vector %0d pkt_sent", v), saw_sent, 1);
      chk(!tx_active && !underflow, $sformatf("R9 vector %0d no abort", v), underflow, 0);
    end
    whiten_en = 0; manch_en = 0;

    // R2 threshold boundary
    clear(); ae_level = 8'd4;
    for (int k = 0; k < 4; k++) push(8'(k));
    @(negedge clk);
    chk(ae_flag, "R2 level equal threshold", ae_flag, 1);
    push(8'h44); @(negedge clk);
    chk(!ae_flag, "R2 level above threshold", ae_flag, 0);

    // R3 clear
    ae_level = 8'd0; @(negedge clk);
    chk(!ae_flag, "R3 before clear", ae_flag, 0);
    @(negedge clk); fifo_clr = 1; wr_en = 1; wr_data = 8'h77;
    @(negedge clk); fifo_clr = 0; wr_en = 0;
    @(negedge clk);
    chk(ae_flag, "R3 after clear", ae_flag, 1);

    // R1 small depth: 70 offered, only 64 kept -> R9 underflow on byte 65
    fifo_big = 0; pre_len = 0; sync_len = 0; fld_en = 0; crc_sel = 0; fld_len = 40'd65;
    for (int k = 0; k < 70; k++) begin pay[k] = 8'(k * 13 + 1); push(pay[k]); end
    capture();
    chk(underflow, "R1 R9 small FIFO underflow", underflow, 1);
    chk(!saw_sent, "R9 no pkt_sent on abort", saw_sent, 0);
    chk(cap_n == 520, "R9 abort at byte boundary", cap_n, 520);
    fld_len = 40'd64; build_exp();
    cmp_stream("R1 first 64 bytes intact", 520);

    // R1 large depth, wrap, dropped write on full
    clear(); fifo_big = 1; ae_level = 8'd128;
    for (int k = 0; k < 129; k++) begin pay[k] = 8'(k * 7 + 3); push(pay[k]); end
    @(negedge clk);
    chk(!ae_flag, "R1 129 bytes stored", ae_flag, 0);
    push(8'hEE);
    fld_len = 40'd129; build_exp();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(!underflow && tx_active, "R9 start clears underflow", underflow, 0);
    sym_stb = 1; cap_n = 0;
    while (tx_active && cap_n < 4096) begin cap_b[cap_n] = tx_bit; cap_n++; @(negedge clk); end
    saw_sent = pkt_sent; sym_stb = 0;
    chk(cap_n == 1040, "R1 large packet length", cap_n, 1040);
    cmp_stream("R1 large FIFO stream", 1040);
    chk(saw_sent, "R8 large packet pkt_sent", saw_sent, 1);
    clear(); fifo_big = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule